// File: doc/BRIEF.md
# Packed BCD Byte Arithmetic Unit

This unit performs decimal arithmetic on bytes that each hold two packed BCD digits. It supports three operations. Add-with-extend adds the source, the destination and the incoming extend flag. Subtract-with-extend takes the source and the extend flag away from the destination. Negate-with-extend subtracts the destination operand and the extend flag from zero. Each operation returns a result byte together with updated carry, extend and zero flags. The zero flag is sticky, so a chain of byte operations that runs from the least significant byte upward leaves zero set only when every byte of a multi-byte decimal number came out zero.

The binary-to-decimal correction uses a bias-and-undo scheme. Each digit is biased by six before a plain binary add. The per-digit carries are then recovered with XOR. The bias is removed again from every digit that did not carry. Subtraction reuses the negate path, which folds the extend flag into a ten's complement, and then feeds that complement into the add path.

The destination arrives as a full register word. Only its low byte is replaced, so the upper bits come back unchanged. For the memory forms of add and subtract, the unit also returns both operand pointers after a one-byte predecrement. All outputs are registered and appear one clock after the request.

Top module: `bcd_byte_alu`

## Requirements
- R1: With op = 2'b00 and valid BCD digits, res_word[7:0] is the BCD encoding of (src + dst + x_in) mod 100, and c_out = x_out = 1 exactly when that sum exceeds 99.
- R2: With op = 2'b01 and valid BCD digits, res_word[7:0] is the BCD encoding of (dst - src - x_in) mod 100, and c_out = x_out = 1 exactly when dst < src + x_in.
- R3: With op[1] = 1, res_word[7:0] is the BCD encoding of (0 - dst - x_in) mod 100, and c_out = x_out = 1 exactly when dst + x_in is nonzero. src_byte has no effect on this operation.
- R4: Both op = 2'b10 and op = 2'b11 select negate.
- R5: z_out is 0 when res_word[7:0] is nonzero; otherwise z_out equals z_in. An operation never raises z_out when z_in is 0.
- R6: res_word[REG_W-1:8] equals dst_word[REG_W-1:8] of the same request.
- R7: When mem_form = 1 and op[1] = 0, src_ptr_out = src_ptr - 1 and dst_ptr_out = dst_ptr - 1, both modulo 2^ADDR_W. Otherwise both pointers pass through unchanged.
- R8: Outputs update on the clock edge that samples in_valid = 1, and out_valid is high for exactly that following cycle. While in_valid = 0, every data and flag output holds its value.
- R9: During and right after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | 00 add, 01 subtract, 1x negate |
| mem_form | input | 1 | Memory operand form: predecrement pointers |
| x_in | input | 1 | Incoming extend flag |
| z_in | input | 1 | Incoming zero flag |
| src_byte | input | 8 | Source BCD byte |
| dst_word | input | REG_W | Destination register word; low byte is the operand |
| src_ptr | input | ADDR_W | Source address pointer |
| dst_ptr | input | ADDR_W | Destination address pointer |
| out_valid | output | 1 | Result valid, one cycle after request |
| res_word | output | REG_W | Destination word with the low byte replaced |
| c_out | output | 1 | Decimal carry/borrow |
| x_out | output | 1 | Extend flag, copy of carry |
| z_out | output | 1 | Sticky zero flag |
| src_ptr_out | output | ADDR_W | Source pointer after optional predecrement |
| dst_ptr_out | output | ADDR_W | Destination pointer after optional predecrement |

## Verification
The hardest cases to reach are the ones where the extend flag alone moves a result across a decade boundary. Examples are subtracting 99 plus extend from 00, and adding 99, 99 and extend. In these cases the internal correction must undo the bias in both digits, or in neither. Sparse patterns seldom produce them. For that reason, the stimulus sweeps every valid BCD source and destination pair with the extend flag both clear and set, for add and for subtract. It also sweeps every negate operand, while the sticky zero input and the upper register bits vary with the loop indices.

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic              mem_form,
  input  logic              x_in,
  input  logic              z_in,
  input  logic [7:0]        src_byte,
  input  logic [REG_W-1:0]  dst_word,
  input  logic [ADDR_W-1:0] src_ptr,
  input  logic [ADDR_W-1:0] dst_ptr,
  output logic              out_valid,
  output logic [REG_W-1:0]  res_word,
  output logic              c_out,
  output logic              x_out,
  output logic              z_out,
  output logic [ADDR_W-1:0] src_ptr_out,
  output logic [ADDR_W-1:0] dst_ptr_out
);

  localparam int HI_W = REG_W - 8;

  logic        is_neg, is_sub;
  logic [15:0] dst_ext;
  logic [15:0] n_in, n_neg, n_t, n_s, n_m, n_res;
  logic [15:0] a_opnd, a_bias, a_sum, a_cy, a_m, a_res;
  logic [15:0] fin;
  logic        cin, carry, dec_ptr;

  assign is_neg  = op[1];
  assign is_sub  = (op == 2'b01);
  assign dst_ext = {8'h00, dst_word[7:0]};

  // ten's complement of (operand + X): negate path, also feeds subtract
  assign n_in  = is_sub ? {8'h00, src_byte} : dst_ext;
  assign n_neg = 16'h0000 - n_in;
  assign n_t   = (n_neg + 16'hFFFF) ^ {15'd0, ~x_in};
  assign n_s   = n_neg - {15'd0, x_in};
  assign n_m   = ~(n_t ^ n_s) & 16'h0110;
  assign n_res = n_s - ((n_m >> 2) | (n_m >> 3));

  // biased binary add, then undo the bias in digits that did not carry
  assign cin    = ~is_sub & x_in;
  assign a_opnd = is_sub ? n_res : {8'h00, src_byte};
  assign a_bias = a_opnd + 16'h0066;
  assign a_sum  = a_bias + dst_ext + {15'd0, cin};
  assign a_cy   = a_bias ^ dst_ext ^ a_sum;
  assign a_m    = ~a_cy & 16'h0110;
  assign a_res  = a_sum - ((a_m >> 2) | (a_m >> 3));

  assign fin     = is_neg ? n_res : a_res;
  assign carry   = |fin[15:8];
  assign dec_ptr = mem_form & ~is_neg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      res_word    <= '0;
      c_out       <= 1'b0;
      x_out       <= 1'b0;
      z_out       <= 1'b0;
      src_ptr_out <= '0;
      dst_ptr_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_word    <= {dst_word[REG_W-1:8], fin[7:0]};
        c_out       <= carry;
        x_out       <= carry;
        z_out       <= (fin[7:0] != 8'h00) ? 1'b0 : z_in;
        src_ptr_out <= dec_ptr ? src_ptr - ADDR_W'(1) : src_ptr;
        dst_ptr_out <= dec_ptr ? dst_ptr - ADDR_W'(1) : dst_ptr;
      end
    end
  end

  AST_Z_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !z_in |=> !z_out); // R5
  AST_Z_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (res_word[7:0] != 8'h00) |-> !z_out); // R5
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_word[REG_W-1:8] == $past(dst_word[REG_W-1:8])); // R6
  AST_PTR_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mem_form && !op[1] |=> src_ptr_out == $past(src_ptr) - ADDR_W'(1)); // R7
  AST_NEG_PTR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op[1] |=> dst_ptr_out == $past(dst_ptr)); // R7
  AST_NEG_OF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op[1] && dst_word[7:0] == 8'h00 && !x_in |=> !c_out && res_word[7:0] == 8'h00); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(res_word) && $stable(z_out) && $stable(c_out)); // R8

  localparam int UNUSED_HI = HI_W;

endmodule

// File: tb/bcd_byte_alu_test.sv
module bcd_byte_alu_test;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [1:0]        op = 2'b00;
  logic              mem_form = 1'b0;
  logic              x_in = 1'b0;
  logic              z_in = 1'b0;
  logic [7:0]        src_byte = 8'h00;
  logic [REG_W-1:0]  dst_word = '0;
  logic [ADDR_W-1:0] src_ptr = '0;
  logic [ADDR_W-1:0] dst_ptr = '0;
  logic              out_valid;
  logic [REG_W-1:0]  res_word;
  logic              c_out, x_out, z_out;
  logic [ADDR_W-1:0] src_ptr_out, dst_ptr_out;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic              e_valid = 1'b0;
  logic [REG_W-1:0]  e_word = '0;
  logic              e_c = 1'b0;
  logic              e_z = 1'b0;
  logic [ADDR_W-1:0] e_sp = '0;
  logic [ADDR_W-1:0] e_dp = '0;
  string             e_tag = "R9";

  always #4 clk = ~clk;

  bcd_byte_alu #(.REG_W(REG_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .mem_form(mem_form),
    .x_in(x_in), .z_in(z_in), .src_byte(src_byte), .dst_word(dst_word),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .out_valid(out_valid), .res_word(res_word),
    .c_out(c_out), .x_out(x_out), .z_out(z_out),
    .src_ptr_out(src_ptr_out), .dst_ptr_out(dst_ptr_out));

  function automatic int dec(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] enc(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R8 out_valid", 64'(out_valid), 64'(e_valid));
    chk({e_tag, " result"}, 64'(res_word[7:0]), 64'(e_word[7:0]));
    chk("R6 upper bits", 64'(res_word[REG_W-1:8]), 64'(e_word[REG_W-1:8]));
    chk({e_tag, " carry"}, 64'(c_out), 64'(e_c));
    chk({e_tag, " extend"}, 64'(x_out), 64'(e_c));
    chk("R5 zero", 64'(z_out), 64'(e_z));
    chk("R7 src ptr", 64'(src_ptr_out), 64'(e_sp));
    chk("R7 dst ptr", 64'(dst_ptr_out), 64'(e_dp));
  endtask

  task automatic issue(input logic [1:0] o, input logic mf, input logic x, input logic z,
                       input logic [7:0] s, input logic [REG_W-1:0] dw,
                       input logic [ADDR_W-1:0] sp, input logic [ADDR_W-1:0] dp);
    int v;
    logic [7:0] r;
    in_valid = 1'b1; op = o; mem_form = mf; x_in = x; z_in = z;
    src_byte = s; dst_word = dw; src_ptr = sp; dst_ptr = dp;
    if (o == 2'b00) begin
      v = dec(s) + dec(dw[7:0]) + int'(x);
      e_c = (v > 99); r = enc(v % 100); e_tag = "R1";
    end else if (o == 2'b01) begin
      v = dec(dw[7:0]) - dec(s) - int'(x);
      e_c = (v < 0); r = enc((v + 100) % 100); e_tag = "R2";
    end else begin
      v = 0 - dec(dw[7:0]) - int'(x);
      e_c = (v < 0); r = enc((v + 100) % 100); e_tag = (o == 2'b11) ? "R4" : "R3";
    end
    e_valid = 1'b1;
    e_word = {dw[REG_W-1:8], r};
    e_z = (r != 8'h00) ? 1'b0 : z;
    e_sp = (mf && !o[1]) ? sp - 1 : sp;
    e_dp = (mf && !o[1]) ? dp - 1 : dp;
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    in_valid = 1'b0;
    src_byte = ~src_byte; dst_word = ~dst_word; x_in = ~x_in; z_in = ~z_in;
    e_valid = 1'b0;
    @(negedge clk);
    compare();
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    e_tag = "R9";
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // directed corners
    issue(2'b00, 1'b0, 1'b1, 1'b1, 8'h99, 32'h1234_5699, 32'h10, 32'h20); // R1 199
    issue(2'b01, 1'b0, 1'b1, 1'b1, 8'h99, 32'hAAAA_AA00, 32'h10, 32'h20); // R2 -100
    issue(2'b10, 1'b0, 1'b0, 1'b1, 8'h55, 32'h0000_0000, 32'h0, 32'h0);   // R3 zero
    issue(2'b11, 1'b1, 1'b1, 1'b0, 8'h00, 32'hFFFF_FF00, 32'h0, 32'h0);   // R4 R7
    issue(2'b00, 1'b1, 1'b0, 1'b1, 8'h01, 32'h0000_0002, 32'h0, 32'h0);   // R7 wrap
    idle();
    idle();

    for (int s = 0; s < 100; s++)
      for (int d = 0; d < 100; d++)
        for (int x = 0; x < 2; x++) begin
          issue(2'b00, 1'(d[0]), 1'(x), 1'(s[1]), enc(s),
                {24'(s * 977 + d * 31 + x), enc(d)}, 32'(s * 3 + x), 32'(d * 5));
          issue(2'b01, 1'(s[0]), 1'(x), 1'(d[1]), enc(s),
                {24'(d * 733 + s), enc(d)}, 32'(d), 32'(s * 7 + x));
          if (((s + d + x) % 11) == 0) idle();
        end

    for (int d = 0; d < 100; d++)
      for (int x = 0; x < 2; x++) begin
        issue(2'b10, 1'(d[0]), 1'(x), 1'(d[2]), 8'(d * 37 + x),
              {24'(d * 4099), enc(d)}, 32'(d), 32'(d + 9));
        issue(2'b11, 1'b1, 1'(x), 1'b1, 8'(d), {24'(d), enc(d)}, 32'(d), 32'(d));
      end
    idle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule